// File: doc/BRIEF.md
# Serial Command Receiver and Zone Register File for a Line Sensor

This block is the control-side front end of a line-sensor controller. It is clocked by a single serial clock. A controller drives bytes onto a one-wire input, and each byte is framed by a low start bit. The block turns those bytes into one-cycle command pulses for a separate readout sequencer. Those pulses cover clearing the integrators, starting integration, sampling, reading out, aborting, and two combined sequences.

The block also holds a small register file. It has an offset and a gain for each of three pixel zones, plus a mode word whose sleep bit is brought out as a pin. Two-byte write commands update these registers. A read command sends one register back on a serial output that changes on the falling clock edge, after a fixed latency. Receiving and sending are independent of each other, so a new command can arrive while a reply is still on the wire.

Top module: `lsc_cmd_slave`

## Requirements
- R1: The input idles high. A byte is a low start bit followed by 8 data bits, least significant first, all sampled on rising edges. No stop bit is needed: a new start bit may follow the last data bit at once, and any number of extra high bits between bytes is ignored.
- R2: While `rst` is high at a rising edge, the following values are set. All zone offsets, zone gains and the mode word become 0. Every strobe output is 0. `sdo` is 1.
- R3: Action codes give a one-cycle pulse on one strobe: 0x0C on `stb_clear`, 0x08 on `stb_integ`, 0x10 on `stb_sample`, 0x02 on `stb_readout` and 0x03 on `stb_abort`. The pulse is high for the cycle after the first rising edge that follows the edge sampling the code's last bit.
- R4: Code 0x06 pulses `stb_sample` and `stb_readout` together. Code 0x0E pulses `stb_sample`, `stb_readout` and `stb_integ` together. The timing is the same as in R3.
- R5: A byte with bits 7:5 = 010 is a write command, and bits 4:0 hold the address. The next byte is the data. The register map is: zone z offset at address 2z and zone z gain at address 2z+1, for z = 0..2, and the mode word at 0x1F. The target register shows the new value after the first rising edge that follows the data byte's last bit.
- R6: The byte after a write command is always taken as data. It never raises a strobe, even when its value equals an action code.
- R7: A gain register keeps only bits 4:0 of the data it is written with, and it reads back with bits 7:5 as zero. Offsets and the mode word keep all 8 bits.
- R8: `sleep` always equals bit 4 of the mode word.
- R9: A write to an address outside the map changes no register. A read from such an address returns 0.
- R10: A byte with bits 7:5 = 100 reads the register at bits 4:0. `sdo` stays high until the falling edge after the 4th rising edge that follows the command's last bit. At that falling edge it drives a 0 start bit. On each following falling edge it drives one data bit, least significant first. One high stop bit follows, and the line then stays high.
- R11: Commands are received while a reply is being sent. Code 0x1B (interface reset) ends any reply in progress. `sdo` is high from the falling edge after the 2nd rising edge that follows that code's last bit. No strobe pulses for 0x1B.
- R12: If `rst` is raised between a write command and its data byte, the pending write is dropped. The next byte is then decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; input sampled on the rising edge, output changes on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial command input, idle high |
| sdo | output | 1 | Serial reply output, idle high |
| stb_clear | output | 1 | Pulse: clear integrators and readout |
| stb_integ | output | 1 | Pulse: begin integration |
| stb_sample | output | 1 | Pulse: end integration and sample |
| stb_readout | output | 1 | Pulse: begin pixel readout |
| stb_abort | output | 1 | Pulse: stop a readout in progress |
| zone_offset | output | 24 | Offsets; zone z at bits 8z+7:8z |
| zone_gain | output | 15 | Gains; zone z at bits 5z+4:5z |
| mode_word | output | 8 | Mode register |
| sleep | output | 1 | Sleep enable from the mode word |

## Verification
The hardest case to reach is an interface-reset code that arrives while a read reply is halfway out. The reply starts only a few cycles after the read command, so the reset byte has to begin on the very next clock after the read's last bit. The bench starts that byte in parallel with watching the reply's first bits. It then checks that the bits which a full reply would hold at 0 come out high. Random write sequences with zero, one or two idle bits between bytes, and some writes to unused addresses, are compared against a model and then read back over the serial reply.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned OPC_W  = BYTE_W - ADDR_W;

  localparam logic [OPC_W-1:0] OPC_WRITE = 3'b010;
  localparam logic [OPC_W-1:0] OPC_READ  = 3'b100;

  localparam logic [BYTE_W-1:0] CODE_IFRST       = 8'h1B;
  localparam logic [BYTE_W-1:0] CODE_CLEAR       = 8'h0C;
  localparam logic [BYTE_W-1:0] CODE_INTEG       = 8'h08;
  localparam logic [BYTE_W-1:0] CODE_SAMPLE      = 8'h10;
  localparam logic [BYTE_W-1:0] CODE_READOUT     = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_ABORT       = 8'h03;
  localparam logic [BYTE_W-1:0] CODE_HOLD_READ   = 8'h06;
  localparam logic [BYTE_W-1:0] CODE_HOLD_READ_I = 8'h0E;

  typedef struct packed {
    logic clear;
    logic integ;
    logic sample;
    logic readout;
    logic abort;
  } strobe_t;

  // Map an action code to the strobes it raises; unknown codes raise none.
  function automatic strobe_t decode_action(input logic [BYTE_W-1:0] code);
    strobe_t s;
    s = '0;
    case (code)
      CODE_CLEAR:       s.clear   = 1'b1;
      CODE_INTEG:       s.integ   = 1'b1;
      CODE_SAMPLE:      s.sample  = 1'b1;
      CODE_READOUT:     s.readout = 1'b1;
      CODE_ABORT:       s.abort   = 1'b1;
      CODE_HOLD_READ:   begin s.sample = 1'b1; s.readout = 1'b1; end
      CODE_HOLD_READ_I: begin s.sample = 1'b1; s.readout = 1'b1; s.integ = 1'b1; end
      default:          s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [OPC_W-1:0] opcode_of(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:ADDR_W];
  endfunction
endpackage

// File: rtl/lsc_rx.sv
module lsc_rx #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  output logic              byte_vld,
  output logic [WORD_W-1:0] byte_data
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             busy;
  logic [CNT_W-1:0] bit_cnt;
  logic [WORD_W-1:0] shreg;

  // event wire: a start bit is being taken on this edge
  logic start_seen;
  assign start_seen = !busy && !sdi;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (!busy) begin
        if (start_seen) begin
          busy    <= 1'b1;
          bit_cnt <= '0;
        end
      end else begin
        shreg   <= {sdi, shreg[WORD_W-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          busy     <= 1'b0;
          byte_vld <= 1'b1;
        end
      end
    end
  end

  assign byte_data = shreg;

  // R1: a completed byte is only ever reported right after a frame in flight
  p_vld_ends_frame_r1: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> $past(busy));

  // R1: receiver is ready for a new start bit in the cycle a byte completes
  p_ready_after_byte_r1: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> !busy);
endmodule

// File: rtl/lsc_regs.sv
module lsc_regs #(
  parameter int unsigned ZONES     = 3,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned GAIN_W    = 5,
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned AW        = 5,
  parameter logic [AW-1:0] MODE_AT = 5'h1F
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [WORD_W-1:0]       rd_val,
  output logic [ZONES*OFS_W-1:0]  zone_offset,
  output logic [ZONES*GAIN_W-1:0] zone_gain,
  output logic [WORD_W-1:0]       mode_word
);
  logic [OFS_W-1:0]  ofs_q  [ZONES];
  logic [GAIN_W-1:0] gain_q [ZONES];
  logic [WORD_W-1:0] mode_q;

  // event wire: the write lands on a mapped register
  logic wr_hit;
  assign wr_hit = wr_en && ((wr_addr < AW'(2*ZONES)) || (wr_addr == MODE_AT));

  for (genvar z = 0; z < ZONES; z++) begin : g_zone
    localparam logic [AW-1:0] OFS_AT  = AW'(2*z);
    localparam logic [AW-1:0] GAIN_AT = AW'(2*z + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        ofs_q[z]  <= '0;
        gain_q[z] <= '0;
      end else if (wr_en) begin
        if (wr_addr == OFS_AT)  ofs_q[z]  <= wr_data[OFS_W-1:0];
        if (wr_addr == GAIN_AT) gain_q[z] <= wr_data[GAIN_W-1:0];
      end
    end
    assign zone_offset[z*OFS_W +: OFS_W]   = ofs_q[z];
    assign zone_gain[z*GAIN_W +: GAIN_W]   = gain_q[z];
  end

  always_ff @(posedge clk) begin
    if (rst)                            mode_q <= '0;
    else if (wr_en && wr_addr == MODE_AT) mode_q <= wr_data;
  end
  assign mode_word = mode_q;

  always_comb begin
    rd_val = '0;
    for (int z = 0; z < ZONES; z++) begin
      if (rd_addr == AW'(2*z))     rd_val = WORD_W'(ofs_q[z]);
      if (rd_addr == AW'(2*z + 1)) rd_val = WORD_W'(gain_q[z]);
    end
    if (rd_addr == MODE_AT) rd_val = mode_q;
  end

  // R9: a write outside the map leaves every register untouched
  p_unmapped_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit) |=> ($stable(zone_offset) && $stable(zone_gain) && $stable(mode_word)));

  // R5: registers move only on a write
  p_regs_move_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(zone_offset) && $stable(zone_gain) && $stable(mode_word)));
endmodule

// File: rtl/lsc_cmd.sv
module lsc_cmd
  import lsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [BYTE_W-1:0] rd_val,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output strobe_t           strobes,
  output logic              rd_go,
  output logic [BYTE_W-1:0] rd_word,
  output logic              flush
);
  logic              pend;
  logic [ADDR_W-1:0] pend_addr;

  // event wires for the checks below
  logic data_phase_byte;
  logic cmd_phase_byte;
  assign data_phase_byte = byte_vld && pend;
  assign cmd_phase_byte  = byte_vld && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      strobes   <= '0;
      rd_go     <= 1'b0;
      rd_word   <= '0;
      flush     <= 1'b0;
    end else begin
      strobes <= '0;
      rd_go   <= 1'b0;
      flush   <= 1'b0;
      if (data_phase_byte) begin
        pend <= 1'b0;
      end else if (cmd_phase_byte) begin
        if (opcode_of(byte_data) == OPC_WRITE) begin
          pend      <= 1'b1;
          pend_addr <= byte_data[ADDR_W-1:0];
        end else if (opcode_of(byte_data) == OPC_READ) begin
          rd_go   <= 1'b1;
          rd_word <= rd_val;
        end else if (byte_data == CODE_IFRST) begin
          flush <= 1'b1;
        end else begin
          strobes <= decode_action(byte_data);
        end
      end
    end
  end

  assign wr_en   = data_phase_byte;
  assign wr_addr = pend_addr;
  assign wr_data = byte_data;
  assign rd_addr = byte_data[ADDR_W-1:0];

  // R3: every strobe pulse is caused by a byte completed one cycle earlier
  p_strobe_from_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (|strobes) |-> $past(cmd_phase_byte));

  // R6: a data byte never produces a strobe
  p_data_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    data_phase_byte |=> (strobes == '0));

  // R3: strobes last a single cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    (|strobes) |=> (strobes == '0));

  // R11: a reply request and an interface reset never coincide
  p_flush_excl_read_r11: assert property (@(posedge clk) disable iff (rst)
    !(flush && rd_go));
endmodule

// File: rtl/lsc_tx.sv
module lsc_tx #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned READ_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              flush,
  output logic              sdo
);
  localparam int unsigned FRAME_W = WORD_W + 2;
  localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);
  localparam int unsigned DLY_W   = (READ_LAT > 2) ? $clog2(READ_LAT) : 1;
  localparam logic [DLY_W-1:0] LOAD_DLY = DLY_W'(READ_LAT - 3);

  logic               active;
  logic [DLY_W-1:0]   dly;
  logic [LEFT_W-1:0]  left;
  logic [FRAME_W-1:0] frame;
  logic               bit_q;

  // event wire: start bit is placed on this edge
  logic start_evt;
  assign start_evt = active && (dly == '0) && (left == LEFT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      active <= 1'b0;
      dly    <= '0;
      left   <= '0;
      frame  <= '1;
      bit_q  <= 1'b1;
    end else if (rd_go) begin
      active <= 1'b1;
      dly    <= LOAD_DLY;
      left   <= LEFT_W'(FRAME_W);
      frame  <= {1'b1, rd_word, 1'b0};
    end else if (active) begin
      if (dly != '0) begin
        dly <= dly - 1'b1;
      end else begin
        bit_q <= frame[0];
        frame <= {1'b1, frame[FRAME_W-1:1]};
        left  <= left - 1'b1;
        if (left == LEFT_W'(1)) active <= 1'b0;
      end
    end
  end

  // output changes on the falling edge
  always_ff @(negedge clk) begin
    if (rst) sdo <= 1'b1;
    else     sdo <= bit_q;
  end

  // R10: the start bit is placed a fixed number of cycles after the request
  p_reply_latency_r10: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> $past(rd_go, READ_LAT - 2));

  // R11: an interface reset leaves the line high and the sender idle
  p_flush_silences_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (bit_q && !active));

  // R10: the line is high whenever no frame is in flight
  p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
    (!active && !$past(active)) |-> bit_q);
endmodule

// File: rtl/lsc_cmd_slave.sv
module lsc_cmd_slave
  import lsc_pkg::*;
#(
  parameter int unsigned ZONES     = 3,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned GAIN_W    = 5,
  parameter int unsigned READ_LAT  = 4,
  parameter int unsigned SLEEP_BIT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sdi,
  output logic                    sdo,
  output logic                    stb_clear,
  output logic                    stb_integ,
  output logic                    stb_sample,
  output logic                    stb_readout,
  output logic                    stb_abort,
  output logic [ZONES*OFS_W-1:0]  zone_offset,
  output logic [ZONES*GAIN_W-1:0] zone_gain,
  output logic [BYTE_W-1:0]       mode_word,
  output logic                    sleep
);
  localparam logic [ADDR_W-1:0] MODE_AT = '1;

  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  logic [BYTE_W-1:0] rd_val;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  strobe_t           strobes;
  logic              rd_go;
  logic [BYTE_W-1:0] rd_word;
  logic              flush;

  lsc_rx #(.WORD_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .sdi(sdi),
    .byte_vld(byte_vld), .byte_data(byte_data)
  );

  lsc_cmd u_cmd (
    .clk(clk), .rst(rst),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .rd_val(rd_val), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .strobes(strobes), .rd_go(rd_go), .rd_word(rd_word), .flush(flush)
  );

  lsc_regs #(
    .ZONES(ZONES), .OFS_W(OFS_W), .GAIN_W(GAIN_W),
    .WORD_W(BYTE_W), .AW(ADDR_W), .MODE_AT(MODE_AT)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_val(rd_val),
    .zone_offset(zone_offset), .zone_gain(zone_gain), .mode_word(mode_word)
  );

  lsc_tx #(.WORD_W(BYTE_W), .READ_LAT(READ_LAT)) u_tx (
    .clk(clk), .rst(rst),
    .rd_go(rd_go), .rd_word(rd_word), .flush(flush),
    .sdo(sdo)
  );

  assign stb_clear   = strobes.clear;
  assign stb_integ   = strobes.integ;
  assign stb_sample  = strobes.sample;
  assign stb_readout = strobes.readout;
  assign stb_abort   = strobes.abort;
  assign sleep       = mode_word[SLEEP_BIT];

  // R4: combined codes only ever raise sample together with readout
  p_combined_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (stb_integ && stb_sample) |-> stb_readout);

  // R2: after reset the strobes are quiet
  p_reset_quiet_r2: assert property (@(posedge clk)
    $past(rst) |-> (strobes == '0));
endmodule

// File: tb/test_lsc_cmd_slave.sv
module test_lsc_cmd_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b1;
  logic sdo;
  logic stb_clear, stb_integ, stb_sample, stb_readout, stb_abort;
  logic [23:0] zone_offset;
  logic [14:0] zone_gain;
  logic [7:0]  mode_word;
  logic        sleep;

  always #5 clk = ~clk;

  lsc_cmd_slave i_lsc_cmd_slave (
    .clk(clk), .rst(rst), .sdi(sdi), .sdo(sdo),
    .stb_clear(stb_clear), .stb_integ(stb_integ), .stb_sample(stb_sample),
    .stb_readout(stb_readout), .stb_abort(stb_abort),
    .zone_offset(zone_offset), .zone_gain(zone_gain),
    .mode_word(mode_word), .sleep(sleep)
  );

  // strobe vector order: clear, integ, sample, readout, abort
  localparam logic [4:0] S_CLR = 5'b10000, S_INT = 5'b01000, S_SMP = 5'b00100,
                         S_RDO = 5'b00010, S_ABT = 5'b00001;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_ofs  [3];
  logic [4:0] m_gain [3];
  logic [7:0] m_mode;

  function automatic logic [4:0] stb_vec();
    return {stb_clear, stb_integ, stb_sample, stb_readout, stb_abort};
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    if (a < 5'd6) return a[0] ? {3'b000, m_gain[a >> 1]} : m_ofs[a >> 1];
    if (a == 5'h1F) return m_mode;
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int z = 0; z < 3; z++) begin m_ofs[z] = '0; m_gain[z] = '0; end
    m_mode = '0;
  endtask

  task automatic model_write(input logic [4:0] a, input logic [7:0] d);
    if (a < 5'd6) begin
      if (a[0]) m_gain[a >> 1] = d[4:0];
      else      m_ofs[a >> 1]  = d;
    end else if (a == 5'h1F) m_mode = d;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    logic [23:0] eo;
    logic [14:0] eg;
    eo = {m_ofs[2], m_ofs[1], m_ofs[0]};
    eg = {m_gain[2], m_gain[1], m_gain[0]};
    chk(zone_offset == eo, {tag, " offsets"}, 32'(zone_offset), 32'(eo));
    chk(zone_gain == eg, {tag, " gains"}, 32'(zone_gain), 32'(eg));
    chk(mode_word == m_mode, {tag, " mode"}, 32'(mode_word), 32'(m_mode));
    chk(sleep == m_mode[4], {tag, " R8 sleep"}, 32'(sleep), 32'(m_mode[4]));
  endtask

  // drive start bit and 8 data bits; returns right after the last bit is driven
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) sdi = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sdi = b[i];
    end
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sdi = 1'b1;
    end
  endtask

  // after send_byte: pass the sampling edge, release the line, pass the decode edge
  task automatic to_decode_edge();
    @(posedge clk);
    @(negedge clk) sdi = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic action_check(input logic [7:0] code, input logic [4:0] exp, input string tag);
    send_byte(code);
    to_decode_edge();
    chk(stb_vec() == exp, $sformatf("%s pulse code %0h", tag, code), 32'(stb_vec()), 32'(exp));
    @(posedge clk); #1;
    chk(stb_vec() == 5'b0, $sformatf("%s single-cycle code %0h", tag, code), 32'(stb_vec()), 32'h0);
  endtask

  task automatic write_reg(input logic [4:0] a, input logic [7:0] d, input int gap);
    send_byte({3'b010, a});
    idle_bits(gap);
    send_byte(d);
    to_decode_edge();
    chk(stb_vec() == 5'b0, $sformatf("R6 data byte %0h raised strobe", d), 32'(stb_vec()), 32'h0);
    model_write(a, d);
    chk_regs($sformatf("R5 write a=%0h d=%0h", a, d));
  endtask

  task automatic read_check(input logic [4:0] a, input string tag);
    logic [9:0] got;
    logic [9:0] exp;
    send_byte({3'b100, a});
    @(posedge clk);
    @(negedge clk) sdi = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(sdo == 1'b1, {tag, " R10 line high before start"}, 32'(sdo), 32'h1);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      got[k] = sdo;
    end
    exp = {1'b1, exp_read(a), 1'b0};
    chk(got == exp, $sformatf("%s R10 reply frame a=%0h", tag, a), 32'(got), 32'(exp));
    @(posedge clk); #1;
    chk(sdo == 1'b1, {tag, " R10 idle after stop"}, 32'(sdo), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    chk_regs("R2 reset");
    chk(stb_vec() == 5'b0, "R2 strobes", 32'(stb_vec()), 32'h0);
    chk(sdo == 1'b1, "R2 sdo", 32'(sdo), 32'h1);
    @(negedge clk) rst = 1'b0;

    // R1: idle high line produces nothing
    idle_bits(20);
    @(posedge clk); #1;
    chk(stb_vec() == 5'b0, "R1 idle line silent", 32'(stb_vec()), 32'h0);

    // R3: each single action code
    action_check(8'h0C, S_CLR, "R3 clear");
    action_check(8'h08, S_INT, "R3 integ");
    action_check(8'h10, S_SMP, "R3 sample");
    action_check(8'h02, S_RDO, "R3 readout");
    action_check(8'h03, S_ABT, "R3 abort");
    // R4: combined codes
    action_check(8'h06, S_SMP | S_RDO, "R4 hold-read");
    action_check(8'h0E, S_SMP | S_RDO | S_INT, "R4 hold-read-integ");
    // unknown code and interface reset raise nothing
    action_check(8'h55, 5'b0, "R3 unknown");
    action_check(8'h1B, 5'b0, "R11 ifreset no strobe");

    // R1: back-to-back bytes with no stop bit; R6: data equal to an action code
    write_reg(5'd0, 8'h08, 0);
    write_reg(5'd3, 8'hFF, 0);   // R7 gain truncated
    read_check(5'd3, "R7 gain readback");
    write_reg(5'h1F, 8'h10, 2);  // R8 sleep set
    write_reg(5'd4, 8'h9C, 1);
    read_check(5'd0, "R5 offset0");
    read_check(5'h1F, "R8 mode");

    // R9: unmapped addresses
    write_reg(5'd7, 8'hA5, 0);
    write_reg(5'h10, 8'h3C, 1);
    read_check(5'd7, "R9 unmapped read");
    read_check(5'h1E, "R9 unmapped read");

    // R11: interface reset cuts a reply short; gain zone0 = 0x05 so bits 6,7 would be 0
    write_reg(5'd1, 8'h05, 0);
    send_byte({3'b100, 5'd1});
    @(posedge clk);
    fork
      send_byte(8'h1B);
      begin
        repeat (5) @(posedge clk);
        #1;
        chk(sdo == 1'b0, "R11 reply started", 32'(sdo), 32'h0);
        @(posedge clk); #1;
        chk(sdo == 1'b1, "R11 reply bit0", 32'(sdo), 32'h1);
      end
    join
    @(posedge clk);
    @(negedge clk) sdi = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(sdo == 1'b1, "R11 cut reply bit6", 32'(sdo), 32'h1);
    @(posedge clk); #1;
    chk(sdo == 1'b1, "R11 cut reply bit7", 32'(sdo), 32'h1);
    repeat (4) @(posedge clk);

    // R12: reset between write command and data
    send_byte({3'b010, 5'd2});
    to_decode_edge();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    model_reset();
    action_check(8'h08, S_INT, "R12 byte after reset is a command");
    chk_regs("R12 no stale write");

    // random writes with random gaps, then full readback
    for (int n = 0; n < 40; n++) begin
      logic [4:0] a;
      int sel;
      sel = int'($urandom_range(0, 7));
      a = (sel < 6) ? 5'(sel) : ((sel == 6) ? 5'h1F : 5'(8 + $urandom_range(0, 20)));
      write_reg(a, 8'($urandom_range(0, 255)), int'($urandom_range(0, 2)));
    end
    for (int a = 0; a < 6; a++) read_check(5'(a), "R5 random readback");
    read_check(5'h1F, "R5 random mode readback");
    read_check(5'h09, "R9 random unmapped");

    // random action codes
    for (int n = 0; n < 12; n++) begin
      logic [7:0] c;
      logic [4:0] e;
      case ($urandom_range(0, 6))
        0: begin c = 8'h0C; e = S_CLR; end
        1: begin c = 8'h08; e = S_INT; end
        2: begin c = 8'h10; e = S_SMP; end
        3: begin c = 8'h02; e = S_RDO; end
        4: begin c = 8'h03; e = S_ABT; end
        5: begin c = 8'h06; e = S_SMP | S_RDO; end
        default: begin c = 8'h0E; e = S_SMP | S_RDO | S_INT; end
      endcase
      action_check(c, e, "R3 random action");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule